// File: doc/BRIEF.md
# Edge-Sequenced SAR Converter Control

This block is the digital core of a 16-bit successive-approximation converter that sits on a host's parallel bus. The host gives it no start pin and no mode register. Everything is told through falling edges of an active-low chip select, read together with a read/convert level. The first qualifying edge wakes the reference and opens the sampling window. The next edge closes the window and starts the bit search. A later edge with read/convert high puts the finished code on the bus.

The bit search runs one trial per internal clock, from the top bit down. It uses a one-bit comparator input from the analog side and a trial code that it presents to the capacitive DAC. An active-low end-of-conversion flag tells the host that a code is ready. The read/convert level at the edge that starts conversion chooses what happens afterwards: the reference either stays up (standby) or is switched off (shutdown).

The data pins are modelled as a registered value and a separate drive-enable, so that the pad ring can build the three-state buffer. A parameter selects between a full 16-bit bus and a byte-wide bus steered by a high/low byte select. A flag marks the first conversion after leaving shutdown, which the host must treat as a throw-away result.

Top module: `sar_edge_ctrl`

## Requirements
- R1: While reset is high and after its release, the block is idle: `track`=0, `ref_en`=0, `eoc_n`=1, `dq_oe`=0, `wake_pend`=0.
- R2: A chip-select falling edge with `rd_cnv`=0 in idle, standby or shutdown sets `track`=1 and `ref_en`=1. The outputs change 3 clocks after the edge reaches the pin. A falling edge with `rd_cnv`=1 when no unread result exists changes nothing.
- R3: The next chip-select falling edge after acquisition clears `track` and starts conversion with the first trial code 0x8000 on `dac_code`. The `rd_cnv` level at that edge is stored as the power choice: 1 means shutdown, 0 means standby.
- R4: The result equals the largest code not above the input. Each trial bit is kept when `cmp_in`=1, meaning the input is at or above the trial code. The result is straight binary with the most significant bit on bit 15.
- R5: `eoc_n` falls exactly 20 clocks after the chip-select edge that starts conversion: 2 synchroniser stages, 1 decode clock, 16 bit trials and 1 completion clock.
- R6: In the clock where `eoc_n` falls, `ref_en` is 1 after a standby choice and 0 after a shutdown choice.
- R7: `dq_oe` stays 0 during acquisition and conversion. A falling edge with `rd_cnv`=1 while `eoc_n`=0 sets `dq_oe`=1 with the result after 3 clocks. The following rising edge clears `dq_oe` and returns `eoc_n` to 1 after 3 clocks.
- R8: In byte mode, `byte_hi`=1 drives result bits 15:8 and `byte_hi`=0 drives bits 7:0 on `dq_drv`. The selection follows `byte_hi` one clock later while chip select stays low. In wide mode, `byte_hi` has no effect.
- R9: Chip-select edges during conversion are ignored. The result and the `eoc_n` timing stay the same.
- R10: `wake_pend` rises on entering acquisition from shutdown, never from standby or idle, and is 0 once that conversion completes.
- R11: Reset applied while chip select is high returns the block to idle from any state and clears `wake_pend`. The next falling edge with `rd_cnv`=0 starts acquisition.
- R12: Starting a new acquisition while a result is still unread discards that result and sets `eoc_n` back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host (asynchronous) |
| rd_cnv | input | 1 | Read/convert qualifier from the host (asynchronous) |
| byte_hi | input | 1 | High/low byte select for the byte-wide bus |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| ref_en | output | 1 | Reference and reference buffer enable |
| track | output | 1 | 1 while the sampling switch tracks the input |
| dac_code | output | RES | Trial code to the capacitive DAC |
| eoc_n | output | 1 | Active-low end of conversion |
| dq_drv | output | OUT_W | Registered data for the bus pads |
| dq_oe | output | 1 | Drive enable for the bus pads (0 = high impedance) |
| wake_pend | output | 1 | First conversion after shutdown is in progress |

## Verification
Host edges pass through two synchroniser flops and one decode register. A state change caused by a chip-select edge therefore appears 3 clocks after the pin moves. The end-of-conversion flag falls 20 clocks after the edge that starts conversion, and a byte-select change reaches the bus after 1 clock. The bench drives every input on the falling clock edge and counts whole clock periods to the cycle in which each result is due. It samples one falling edge later, and it checks the clock just before the end-of-conversion fall so that an early or late flag is caught.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

  // Sequencer states of the converter control
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,   // after reset, reference off
    ST_ACQ  = 3'd1,   // sampling window open
    ST_CONV = 3'd2,   // bit search running
    ST_STBY = 3'd3,   // done, reference kept on
    ST_SHDN = 3'd4    // done, reference switched off
  } sarc_state_e;

  // Meaning of the stored power choice
  localparam logic PWR_STANDBY  = 1'b0;
  localparam logic PWR_SHUTDOWN = 1'b1;

endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sarc_sar.sv
module sarc_sar #(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           cmp_in,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result,
  output logic           done
);
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] code_q, mask_q, result_q, step_code;
  logic           busy_q, done_q;

  // Keep the bit under test when the input is at or above the trial,
  // then raise the next lower bit as the new trial.
  always_comb begin
    step_code = cmp_in ? code_q : (code_q & ~mask_q);
    step_code = step_code | (mask_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      mask_q   <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        code_q <= TOP_BIT;
        mask_q <= TOP_BIT;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        code_q <= step_code;
        mask_q <= mask_q >> 1;
        if (mask_q[0]) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= step_code;
        end
      end
    end
  end

  assign trial  = code_q;
  assign result = result_q;
  assign done   = done_q;
endmodule

// File: rtl/sarc_outbus.sv
module sarc_outbus #(
  parameter int RES       = 16,
  parameter bit BYTE_MODE = 1'b0,
  parameter int OUT_W     = BYTE_MODE ? RES / 2 : RES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             drop,
  input  logic             byte_hi,
  input  logic [RES-1:0]   result,
  output logic [OUT_W-1:0] dq_drv,
  output logic             dq_oe
);
  logic [OUT_W-1:0] sel_data, drv_q;
  logic             oe_q;

  generate
    if (BYTE_MODE) begin : g_byte
      assign sel_data = byte_hi ? result[RES-1 -: OUT_W] : result[OUT_W-1:0];
    end else begin : g_wide
      logic unused_sel;
      assign unused_sel = byte_hi;
      assign sel_data   = result;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      drv_q <= sel_data;
      if (load)      oe_q <= 1'b1;
      else if (drop) oe_q <= 1'b0;
    end
  end

  assign dq_drv = drv_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/sar_edge_ctrl.sv
module sar_edge_ctrl
  import sarc_pkg::*;
#(
  parameter int RES         = 16,
  parameter bit BYTE_MODE   = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_W       = BYTE_MODE ? RES / 2 : RES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_cnv,
  input  logic             byte_hi,
  input  logic             cmp_in,
  output logic             ref_en,
  output logic             track,
  output logic [RES-1:0]   dac_code,
  output logic             eoc_n,
  output logic [OUT_W-1:0] dq_drv,
  output logic             dq_oe,
  output logic             wake_pend
);
  // Host lines, synchronised
  logic cs_s, rd_s, cs_prev_q, cs_fell, cs_rose;

  sarc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  sarc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rd_sync (
    .clk(clk), .rst(rst), .d(rd_cnv), .q(rd_s));

  always_ff @(posedge clk) begin
    if (rst) cs_prev_q <= 1'b1;
    else     cs_prev_q <= cs_s;
  end
  assign cs_fell = cs_prev_q & ~cs_s;
  assign cs_rose = ~cs_prev_q & cs_s;

  // Sequencer
  sarc_state_e   state_q, state_d;
  logic          mode_q, eoc_n_q, rd_act_q, wake_q, ref_q, trk_q;
  logic          acq_go, conv_go, read_go, read_end, sar_done;
  logic [RES-1:0] sar_result;

  always_comb begin
    state_d = state_q;
    acq_go  = 1'b0;
    conv_go = 1'b0;
    read_go = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_STBY, ST_SHDN: begin
        if (cs_fell) begin
          if (!rd_s) begin
            state_d = ST_ACQ;
            acq_go  = 1'b1;
          end else if (!eoc_n_q) begin
            read_go = 1'b1;
          end
        end
      end
      ST_ACQ: begin
        if (cs_fell) begin
          state_d = ST_CONV;
          conv_go = 1'b1;
        end
      end
      ST_CONV: begin
        if (sar_done) state_d = (mode_q == PWR_SHUTDOWN) ? ST_SHDN : ST_STBY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign read_end = cs_rose & rd_act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= PWR_STANDBY;
      eoc_n_q  <= 1'b1;
      rd_act_q <= 1'b0;
      wake_q   <= 1'b0;
      ref_q    <= 1'b0;
      trk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= (state_d == ST_ACQ) || (state_d == ST_CONV) || (state_d == ST_STBY);
      trk_q   <= (state_d == ST_ACQ);
      if (conv_go) mode_q <= rd_s;
      if (acq_go) begin
        eoc_n_q  <= 1'b1;
        rd_act_q <= 1'b0;
        if (state_q == ST_SHDN) wake_q <= 1'b1;
      end
      if (read_go) rd_act_q <= 1'b1;
      if ((state_q == ST_CONV) && sar_done) begin
        eoc_n_q <= 1'b0;
        wake_q  <= 1'b0;
      end
      if (read_end) begin
        eoc_n_q  <= 1'b1;
        rd_act_q <= 1'b0;
      end
    end
  end

  sarc_sar #(.RES(RES)) u_sar (
    .clk(clk), .rst(rst), .start(conv_go), .cmp_in(cmp_in),
    .trial(dac_code), .result(sar_result), .done(sar_done));

  sarc_outbus #(.RES(RES), .BYTE_MODE(BYTE_MODE), .OUT_W(OUT_W)) u_bus (
    .clk(clk), .rst(rst), .load(read_go), .drop(read_end | acq_go),
    .byte_hi(byte_hi), .result(sar_result), .dq_drv(dq_drv), .dq_oe(dq_oe));

  assign ref_en    = ref_q;
  assign track     = trk_q;
  assign eoc_n     = eoc_n_q;
  assign wake_pend = wake_q;
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk #(
  parameter int RES = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           track,
  input logic           ref_en,
  input logic           eoc_n,
  input logic           dq_oe,
  input logic           wake_pend,
  input logic           mode_q,
  input logic [RES-1:0] dac_code
);
  localparam int CW = $clog2(RES + 2) + 1;
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic          trk_d;
  logic [CW-1:0] conv_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_d    <= 1'b0;
      conv_cnt <= '1;
    end else begin
      trk_d <= track;
      if (trk_d && !track)    conv_cnt <= '0;
      else if (conv_cnt != '1) conv_cnt <= conv_cnt + CW'(1);
    end
  end

  // R2
  track_ref_chk: assert property (@(posedge clk) disable iff (rst)
    track |-> ref_en);

  // R7
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!track && !eoc_n));

  // R3
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(track) && !$past(rst)) |-> (dac_code == TOP_BIT));

  // R5
  conv_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> (conv_cnt == CW'(RES)));

  // R6
  power_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> (ref_en == !mode_q));

  // R10
  wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> !wake_pend);
endmodule

bind sar_edge_ctrl sarc_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst(rst), .track(track), .ref_en(ref_en), .eoc_n(eoc_n),
  .dq_oe(dq_oe), .wake_pend(wake_pend), .mode_q(mode_q), .dac_code(dac_code));

// File: tb/tb_sar_edge_ctrl.sv
`timescale 1ns/1ps
module tb_sar_edge_ctrl;
  localparam int RES = 16;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rd_cnv = 1'b0, byte_hi = 1'b1;
  logic [RES-1:0] vin = '0;
  logic cmp_w, cmp_b;
  logic ref_w, trk_w, eoc_w, oe_w, wk_w;
  logic ref_b, trk_b, eoc_b, oe_b, wk_b;
  logic [RES-1:0] dac_w, dac_b, dq_w;
  logic [7:0] dq_b;
  int n_chk = 0, n_bad = 0;
  bit exp_wake = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp_w = (vin >= dac_w);
  assign cmp_b = (vin >= dac_b);

  sar_edge_ctrl #(.RES(RES), .BYTE_MODE(1'b0)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_cnv(rd_cnv), .byte_hi(byte_hi),
    .cmp_in(cmp_w), .ref_en(ref_w), .track(trk_w), .dac_code(dac_w),
    .eoc_n(eoc_w), .dq_drv(dq_w), .dq_oe(oe_w), .wake_pend(wk_w));

  sar_edge_ctrl #(.RES(RES), .BYTE_MODE(1'b1)) dut_byte (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_cnv(rd_cnv), .byte_hi(byte_hi),
    .cmp_in(cmp_b), .ref_en(ref_b), .track(trk_b), .dac_code(dac_b),
    .eoc_n(eoc_b), .dq_drv(dq_b), .dq_oe(oe_b), .wake_pend(wk_b));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected conversion code with an ideal comparator (R4): the input itself
  function automatic logic [15:0] exp_code(input logic [15:0] v);
    logic [15:0] c = '0;
    for (int b = 15; b >= 0; b--) begin
      c[b] = 1'b1;
      if (c > v) c[b] = 1'b0;
    end
    return c;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] v, input bit hi);
    logic [15:0] c = exp_code(v);
    return hi ? c[15:8] : c[7:0];
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_conv(input logic [15:0] v, input bit mode, input bit glitch, input bit do_read);
    int el;
    vin = v;
    cs_n = 1'b0; rd_cnv = 1'b0; tick(3);
    chk("R2 track on acquisition", 32'(trk_w), 1);
    chk("R2 ref_en on acquisition", 32'(ref_w), 1);
    chk("R12 eoc_n high on new acquisition", 32'(eoc_w), 1);
    chk("R7 bus quiet in acquisition", 32'({oe_w, oe_b}), 0);
    chk("R10 wake_pend on acquisition", 32'(wk_w), 32'(exp_wake));
    cs_n = 1'b1; tick(3);
    cs_n = 1'b0; rd_cnv = mode; tick(3);
    chk("R3 track cleared at convert edge", 32'(trk_w), 0);
    chk("R3 first trial code", 32'(dac_w), 32'h8000);
    cs_n = 1'b1; tick(3);
    el = 6;
    if (glitch) begin
      cs_n = 1'b0; rd_cnv = 1'($urandom % 2); tick(4);
      cs_n = 1'b1; tick(4);
      el = 14;
    end
    tick(19 - el);
    chk("R5 eoc_n still high one clock early", 32'({eoc_w, eoc_b}), 32'h3);
    chk("R7 bus quiet in conversion", 32'({oe_w, oe_b}), 0);
    tick(1);
    chk("R5 R9 eoc_n low on time", 32'({eoc_w, eoc_b}), 0);
    chk("R6 reference after conversion", 32'(ref_w), 32'(!mode));
    chk("R10 wake_pend cleared", 32'(wk_w), 0);
    exp_wake = mode;
    if (do_read) begin
      cs_n = 1'b0; rd_cnv = 1'b1; byte_hi = 1'b1; tick(3);
      chk("R7 bus driven on read", 32'({oe_w, oe_b}), 32'h3);
      chk("R4 R9 wide result", 32'(dq_w), 32'(exp_code(v)));
      chk("R8 high byte", 32'(dq_b), 32'(exp_byte(v, 1'b1)));
      byte_hi = 1'b0; tick(1);
      chk("R8 low byte", 32'(dq_b), 32'(exp_byte(v, 1'b0)));
      chk("R8 wide bus ignores byte_hi", 32'(dq_w), 32'(exp_code(v)));
      byte_hi = 1'b1; tick(1);
      chk("R8 high byte again", 32'(dq_b), 32'(exp_byte(v, 1'b1)));
      cs_n = 1'b1; tick(3);
      chk("R7 bus released on cs rise", 32'({oe_w, oe_b}), 0);
      chk("R7 eoc_n high after read", 32'(eoc_w), 1);
      cs_n = 1'b0; rd_cnv = 1'b1; tick(3);
      chk("R2 read edge without result ignored", 32'({oe_w, trk_w}), 0);
      chk("R2 reference unchanged", 32'(ref_w), 32'(!mode));
      cs_n = 1'b1; tick(3);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    chk("R1 reset state", 32'({trk_w, ref_w, oe_w, wk_w, oe_b}), 0);
    chk("R1 eoc_n during reset", 32'(eoc_w), 1);
    rst = 1'b0; tick(1);
    chk("R1 idle after reset", 32'({trk_w, ref_w, oe_w, wk_w}), 0);
    chk("R1 eoc_n idle", 32'(eoc_w), 1);
    cs_n = 1'b0; rd_cnv = 1'b1; tick(3);
    chk("R2 rd high edge ignored in idle", 32'({trk_w, ref_w, oe_w}), 0);
    cs_n = 1'b1; tick(3);

    run_conv(16'h0000, 1'b0, 1'b0, 1'b1);
    run_conv(16'hFFFF, 1'b1, 1'b0, 1'b1);
    run_conv(16'h8000, 1'b0, 1'b0, 1'b1);   // R10: wake flagged from shutdown
    run_conv(16'h7FFF, 1'b0, 1'b1, 1'b1);   // R9: edges during conversion
    run_conv(16'h1234, 1'b1, 1'b0, 1'b0);   // result left unread
    run_conv(16'hA5A5, 1'b1, 1'b0, 1'b1);   // R12: unread result discarded

    // R11: reset mid-acquisition after shutdown
    cs_n = 1'b0; rd_cnv = 1'b0; tick(3);
    chk("R10 wake_pend set from shutdown", 32'(wk_w), 1);
    cs_n = 1'b1; tick(3);
    rst = 1'b1; tick(2);
    rst = 1'b0; tick(1);
    chk("R11 idle after reset", 32'({trk_w, ref_w, wk_w, oe_w}), 0);
    chk("R11 eoc_n after reset", 32'(eoc_w), 1);
    exp_wake = 1'b0;
    run_conv(16'h0001, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 40; i++) begin
      run_conv(16'($urandom), 1'($urandom % 2), 1'($urandom % 4 == 0),
               1'($urandom % 5 != 0));
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule